// File: doc/BRIEF.md
# Protected Fuse Read Controller

This block fronts a small one-time-programmable fuse store with a 32-bit register bus. It offers two ways to reach fuse contents. Words in the public region can be read at once through a directly mapped window. Every word, public or not, can be reached through a guarded command register. Software writes a word offset, an unlock byte and a request bit into that register. It polls until the request bit drops, then reads the result from a separate result register.

Programming works through the same command register. The word to burn is first placed in a staging register, then a program request is issued. Burning is modelled as a bitwise OR, so a fuse bit that is set never clears. The storage is a register array loaded from a parameter image at reset. Each guarded access takes a fixed, parameterised number of cycles.

Top module: `fuse_prot_ctrl`

## Requirements
- R1: After reset the command register (0x40), the staging register (0x50) and the result register (0x60) all read zero, and the fuse array holds the INIT_IMAGE parameter, where word i sits at bits 32*i+31:32*i.
- R2: A read at 0x200+4*i returns fuse word i when i < PUB_WORDS, with fuse byte 4*i+k at bits 8*k+7:8*k. Window words with i >= PUB_WORDS read zero, and any address that is not decoded reads zero.
- R3: The command register decodes as follows: bits 23:16 are a byte offset whose word index is offset>>2, bits 15:8 are the unlock byte, bit 1 is a read request and bit 0 is a program request. It reads back as {8'h00, offset, unlock byte, 6'b0, read busy, program busy}, holding the fields of the last accepted command.
- R4: An accepted request keeps its bit set for exactly LATENCY cycles after the accepting clock edge, then clears it.
- R5: When a read completes, the result register takes the addressed fuse word. At no other time does it change.
- R6: A command whose unlock byte is not 0xAC is ignored: no request bit sets, and neither the command readback nor the result register changes.
- R7: A command written while a request is in progress is ignored. The running request finishes with its own offset.
- R8: On completion, a program request ORs the staging register into the addressed word, so fuse bits only go from 0 to 1.
- R9: If both request bits are written together, only the read is carried out. A word index of NUM_WORDS or more reads back as zero through the guarded path, and programming it has no effect.
- R10: The staging register at 0x50 can be written and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The bench counts cycles from the accepting edge. A sequencer whose latency is off by one would show the busy bit one edge early or one edge late. It sends commands with a wrong unlock byte and commands written while a request is busy. A design that let either through would start a new access, change the command readback, or overwrite the result register with the wrong word. The bench also writes both request bits at once, and offsets beyond the array. Guarded reads of words that are hidden from the window must still return data, while those words read zero in the window. A program that assigned the word instead of ORing it would show cleared bits in the window. The random phase mixes all of these commands against a model of the fuse array.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam logic [11:0] CTRL_OFS  = 12'h040;
  localparam logic [11:0] STAGE_OFS = 12'h050;
  localparam logic [11:0] RES_OFS   = 12'h060;
  localparam logic [11:0] WIN_BASE  = 12'h200;
  localparam logic [7:0]  UNLOCK_KEY = 8'hAC;

  typedef struct packed {
    logic [7:0] rsvd;
    logic [7:0] off;
    logic [7:0] key;
    logic [5:0] pad;
    logic       rd;
    logic       pg;
  } cmd_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W = 4,
  parameter logic [NUM_WORDS*32-1:0] INIT_IMAGE = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    prog_en_i,
  input  logic [IDX_W-1:0]        prog_idx_i,
  input  logic [31:0]             prog_data_i,
  input  logic [IDX_W-1:0]        win_idx_i,
  input  logic [IDX_W-1:0]        prot_idx_i,
  output logic [31:0]             win_word_o,
  output logic [31:0]             prot_word_o,
  output logic [NUM_WORDS*32-1:0] image_o
);
  logic [31:0] mem_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= INIT_IMAGE[g*32 +: 32];
      else if (prog_en_i && 32'(prog_idx_i) == g) mem_q[g] <= mem_q[g] | prog_data_i;
    end
    assign image_o[g*32 +: 32] = mem_q[g];
  end

  assign win_word_o  = mem_q[win_idx_i];
  assign prot_word_o = mem_q[prot_idx_i];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq #(
  parameter int unsigned LATENCY = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_rd_i,
  input  logic start_pg_i,
  output logic rd_busy_o,
  output logic pg_busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic busy;

  assign busy   = rd_busy_o | pg_busy_o;
  assign done_o = busy && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_busy_o <= 1'b0;
      pg_busy_o <= 1'b0;
      cnt_q     <= '0;
    end else if (!busy && (start_rd_i || start_pg_i)) begin
      rd_busy_o <= start_rd_i;
      pg_busy_o <= start_pg_i && !start_rd_i;  // read wins when both requested
      cnt_q     <= CNT_LOAD;
    end else if (busy) begin
      if (cnt_q == '0) begin
        rd_busy_o <= 1'b0;
        pg_busy_o <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fuse_prot_ctrl.sv
module fuse_prot_ctrl
  import fuse_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned PUB_WORDS = 8,
  parameter int unsigned LATENCY   = 8,
  parameter logic [NUM_WORDS*32-1:0] INIT_IMAGE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned WIN_BYTES = NUM_WORDS * 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAGE = ADDR_W'(STAGE_OFS);
  localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(RES_OFS);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(WIN_BASE);

  cmd_t        wcmd;
  logic        rd_busy, pg_busy, busy, done, accept;
  logic [7:0]  off_q, key_q;
  logic [31:0] stage_q, rdata_q;
  logic [5:0]  cmd_idx;
  logic        idx_ok;
  logic [ADDR_W-1:0] win_off;
  logic        in_win, pub_hit;
  logic [IDX_W-1:0] win_idx;
  logic [31:0] win_word, prot_word;
  logic [NUM_WORDS*32-1:0] img_flat;

  assign wcmd   = wdata_i;
  assign busy   = rd_busy | pg_busy;
  assign accept = we_i && (addr_i == A_CTRL) && (wcmd.key == UNLOCK_KEY)
                  && (wcmd.rd || wcmd.pg) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      key_q <= '0;
    end else if (accept) begin
      off_q <= wcmd.off;
      key_q <= wcmd.key;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else if (we_i && addr_i == A_STAGE) stage_q <= wdata_i;
  end

  fuse_seq #(.LATENCY(LATENCY)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_rd_i (accept && wcmd.rd),
    .start_pg_i (accept && wcmd.pg),
    .rd_busy_o  (rd_busy),
    .pg_busy_o  (pg_busy),
    .done_o     (done)
  );

  assign cmd_idx = off_q[7:2];
  assign idx_ok  = 32'(cmd_idx) < NUM_WORDS;

  assign win_off = addr_i - A_WIN;
  assign in_win  = (addr_i >= A_WIN) && (32'(win_off) < WIN_BYTES);
  assign win_idx = win_off[IDX_W+1:2];
  assign pub_hit = in_win && (32'(win_idx) < PUB_WORDS);

  fuse_array #(
    .NUM_WORDS  (NUM_WORDS),
    .IDX_W      (IDX_W),
    .INIT_IMAGE (INIT_IMAGE)
  ) i_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_en_i   (done && pg_busy && idx_ok),
    .prog_idx_i  (cmd_idx[IDX_W-1:0]),
    .prog_data_i (stage_q),
    .win_idx_i   (win_idx),
    .prot_idx_i  (cmd_idx[IDX_W-1:0]),
    .win_word_o  (win_word),
    .prot_word_o (prot_word),
    .image_o     (img_flat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (done && rd_busy) rdata_q <= idx_ok ? prot_word : 32'h0;
  end

  always_comb begin
    rdata_o = 32'h0;
    if (addr_i == A_CTRL)       rdata_o = {8'h00, off_q, key_q, 6'h00, rd_busy, pg_busy};
    else if (addr_i == A_STAGE) rdata_o = stage_q;
    else if (addr_i == A_RES)   rdata_o = rdata_q;
    else if (pub_hit)           rdata_o = win_word;
  end
endmodule

// File: rtl/fuse_prot_chk.sv
module fuse_prot_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned LATENCY   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    we_i,
  input logic [31:0]             wdata_i,
  input logic                    rd_busy_i,
  input logic                    pg_busy_i,
  input logic [7:0]              off_q_i,
  input logic [31:0]             rdata_q_i,
  input logic [NUM_WORDS*32-1:0] img_i
);
  logic busy, ctrl_wr;
  int unsigned busy_cnt;

  assign busy    = rd_busy_i | pg_busy_i;
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(fuse_pkg::CTRL_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else busy_cnt <= busy ? busy_cnt + 1 : 0;
  end

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({rd_busy_i, pg_busy_i})); // R9
  AST_LAT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni) busy |-> busy_cnt < LATENCY); // R4
  AST_LAT_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy) |-> busy_cnt == LATENCY); // R4
  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[15:8] != fuse_pkg::UNLOCK_KEY && !busy) |=> !busy); // R6
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy) |=> $stable(off_q_i)); // R7
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(rd_busy_i) |-> $stable(rdata_q_i)); // R5
  AST_FUSE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_i & $past(img_i)) == $past(img_i)); // R8
endmodule

bind fuse_prot_ctrl fuse_prot_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_WORDS (NUM_WORDS),
  .LATENCY   (LATENCY)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rd_busy_i (rd_busy),
  .pg_busy_i (pg_busy),
  .off_q_i   (off_q),
  .rdata_q_i (rdata_q),
  .img_i     (img_flat)
);

// File: tb/test_fuse_prot_ctrl.sv
module test_fuse_prot_ctrl;
  localparam int NW  = 16;
  localparam int PUB = 8;
  localparam int LAT = 8;
  localparam logic [11:0] A_CTRL = 12'h040, A_STAGE = 12'h050, A_RES = 12'h060, A_WIN = 12'h200;

  function automatic logic [31:0] img_word(int i);
    return {8'(i) ^ 8'h5A, 8'hC3, 8'(i * 3), 8'h10 + 8'(i)};
  endfunction

  function automatic logic [NW*32-1:0] build_img();
    logic [NW*32-1:0] v;
    for (int i = 0; i < NW; i++) v[i*32 +: 32] = img_word(i);
    return v;
  endfunction

  localparam logic [NW*32-1:0] IMG = build_img();

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;
  logic [31:0] mdl [NW];
  logic [7:0] last_off, last_key;
  logic [31:0] last_res;

  always #10 clk = ~clk;

  fuse_prot_ctrl #(.ADDR_W(12), .NUM_WORDS(NW), .PUB_WORDS(PUB), .LATENCY(LAT), .INIT_IMAGE(IMG)) i_fuse_prot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic peek(logic [11:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      peek(A_CTRL, v);
      if (v[1:0] == 2'b00) return;
      @(negedge clk);
    end
    chk("R4 poll timeout", v, {v[31:2], 2'b00});
  endtask

  function automatic logic [31:0] cmd(logic [7:0] off, logic [7:0] key, logic [1:0] req);
    return {8'h00, off, key, 6'h00, req};
  endfunction

  function automatic logic [31:0] exp_prot(logic [7:0] off);
    int idx = int'(off[7:2]);
    return (idx < NW) ? mdl[idx] : 32'h0;
  endfunction

  function automatic logic [31:0] exp_win(int i);
    return (i < PUB) ? mdl[i] : 32'h0;
  endfunction

  task automatic prot_read(logic [7:0] off, string tag);
    logic [31:0] v;
    wr(A_CTRL, cmd(off, 8'hAC, 2'b10));
    wait_idle();
    peek(A_RES, v);
    chk(tag, v, exp_prot(off));
    last_off = off; last_key = 8'hAC; last_res = exp_prot(off);
  endtask

  task automatic prog(logic [7:0] off, logic [31:0] d);
    int idx = int'(off[7:2]);
    wr(A_STAGE, d);
    wr(A_CTRL, cmd(off, 8'hAC, 2'b01));
    wait_idle();
    if (idx < NW) mdl[idx] = mdl[idx] | d;
    last_off = off; last_key = 8'hAC;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    for (int i = 0; i < NW; i++) mdl[i] = img_word(i);
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(A_CTRL, v);  chk("R1 ctrl reset", v, 32'h0);
    peek(A_STAGE, v); chk("R1 stage reset", v, 32'h0);
    peek(A_RES, v);   chk("R1 result reset", v, 32'h0);
    for (int i = 0; i < NW; i++) begin
      peek(A_WIN + 12'(4 * i), v); chk("R1 R2 window image", v, exp_win(i));
    end
    peek(12'h044, v); chk("R2 undecoded address", v, 32'h0);
    peek(A_WIN + 12'(4 * NW), v); chk("R2 past window end", v, 32'h0);

    // R4 exact latency, R3 readback while busy
    wr(A_CTRL, cmd(8'h04, 8'hAC, 2'b10));
    peek(A_CTRL, v); chk("R3 ctrl readback busy", v, 32'h0004_AC02);
    repeat (LAT - 1) @(negedge clk);
    peek(A_CTRL, v); chk("R4 busy at last cycle", 32'(v[1]), 32'h1);
    @(negedge clk);
    peek(A_CTRL, v); chk("R4 cleared after latency", v, 32'h0004_AC00);
    peek(A_RES, v);  chk("R5 result word 1", v, mdl[1]);

    // R7 command while busy ignored
    wr(A_CTRL, cmd(8'h08, 8'hAC, 2'b10));
    wr(A_CTRL, cmd(8'h0C, 8'hAC, 2'b10));
    peek(A_CTRL, v); chk("R7 busy cmd ignored offset", v, 32'h0008_AC02);
    wait_idle();
    peek(A_RES, v); chk("R7 first request result", v, mdl[2]);

    // R6 wrong key ignored
    wr(A_CTRL, cmd(8'h10, 8'h55, 2'b10));
    peek(A_CTRL, v); chk("R6 bad key no start", v, 32'h0008_AC00);
    repeat (LAT + 2) @(negedge clk);
    peek(A_RES, v); chk("R6 result unchanged", v, mdl[2]);

    // R10 staging register, R8 OR program
    wr(A_STAGE, 32'h0000_F00F);
    peek(A_STAGE, v); chk("R10 stage readback", v, 32'h0000_F00F);
    wr(A_CTRL, cmd(8'h0C, 8'hAC, 2'b01));
    peek(A_CTRL, v); chk("R3 program busy bit", v, 32'h000C_AC01);
    wait_idle();
    mdl[3] = mdl[3] | 32'h0000_F00F;
    peek(A_WIN + 12'h00C, v); chk("R8 ORed word", v, mdl[3]);
    prog(8'h0C, 32'h0);
    peek(A_WIN + 12'h00C, v); chk("R8 zero keeps bits", v, mdl[3]);

    // R9 both bits: read only
    wr(A_STAGE, 32'hFFFF_FFFF);
    wr(A_CTRL, cmd(8'h14, 8'hAC, 2'b11));
    peek(A_CTRL, v); chk("R9 both bits read only", v, 32'h0014_AC02);
    wait_idle();
    peek(A_RES, v); chk("R9 both bits result", v, mdl[5]);
    peek(A_WIN + 12'h014, v); chk("R9 both bits no program", v, mdl[5]);

    // R9 out of range; protected word through guarded path only
    prot_read(8'h80, "R9 out of range reads zero");
    prog(8'hFC, 32'hFFFF_FFFF);
    for (int i = 0; i < NW; i++) begin
      peek(A_WIN + 12'(4 * i), v); chk("R9 out of range program no effect", v, exp_win(i));
    end
    prot_read(8'h30, "R5 hidden word via guarded path");
    peek(A_WIN + 12'h030, v); chk("R2 hidden word in window", v, 32'h0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 4));
      logic [7:0] off = 8'($urandom_range(0, 80));
      case (op)
        0: prot_read(off, "R5 random guarded read");
        1: prog(off, $urandom() & $urandom());
        2: begin
          int i = int'($urandom_range(0, NW + 2));
          peek(A_WIN + 12'(4 * i), v); chk("R2 random window read", v, (i < NW) ? exp_win(i) : 32'h0);
        end
        3: begin
          logic [7:0] k = 8'($urandom_range(0, 255));
          if (k == 8'hAC) k = 8'h00;
          wr(A_CTRL, cmd(off, k, 2'($urandom_range(1, 3))));
          peek(A_CTRL, v); chk("R6 random bad key", v, {8'h00, last_off, last_key, 8'h00});
          peek(A_RES, v);  chk("R6 random bad key result", v, last_res);
        end
        default: begin
          wr(A_CTRL, cmd(off, 8'hAC, 2'b10));
          wr(A_CTRL, cmd(~off, 8'hAC, 2'b01));
          wait_idle();
          peek(A_RES, v); chk("R7 random busy overlap", v, exp_prot(off));
          last_off = off; last_key = 8'hAC; last_res = exp_prot(off);
        end
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule